// File: doc/BRIEF.md
# Emulated Page-Erase Flash Controller

This block puts a word-wide on-chip RAM behind a controller that makes it behave like page-organised embedded flash. Software and fetch logic read the contents through a plain memory port. Any write sent to that port is dropped. Content changes only through a small register file. Software loads a byte address and an operand there, then writes a command code to start a read, a page erase or a word program.

The controller applies the physical rules of flash. An erase is the only way to return bits to 1, and it always covers a whole 1 kB page of 256 words. A program can only clear bits, because the stored word becomes the AND of its old value and the operand. Erase and program both hold the controller busy for a configurable number of clock cycles, with erase much longer than program. This lets firmware meet realistic timing during emulation. Completion sets a sticky flag, and that flag drives a level interrupt until software clears it.

The array size is a whole number of pages set by a parameter. A full-size instance uses 512 pages, giving 512 kB. Commands whose address lies beyond the configured space are refused.

Top module: `eflash_ctrl_top`

## Requirements
- R1: After reset the status register reads 0 (busy bit 0, done bit 1, busy-error bit 2 and range-error bit 3 all clear) and `irq_o` is low.
- R2: A memory-port read (`bus_req_i`=1, `bus_we_i`=0) returns the stored word at byte address `bus_addr_i` on `bus_rdata_o`, with `bus_rvalid_o` high, one cycle later.
- R3: A memory-port write (`bus_we_i`=1) leaves storage unchanged and produces no `bus_rvalid_o`.
- R4: Command code 2 (erase) sets all 256 words of the page holding the address in CSR index 0 to 0xFFFFFFFF, and leaves every other page unchanged.
- R5: Command code 3 (program) stores the bitwise AND of the old word and the operand in CSR index 1. Repeated programs of the same word keep accumulating the AND.
- R6: After a command is accepted, the busy bit stays set for exactly ERASE_CYCLES cycles for an erase, PROG_CYCLES for a program and 1 for a read.
- R7: Command code 1 (read) copies the addressed word into CSR index 4 by the time busy drops.
- R8: A command written while busy is rejected, sets the busy-error bit and does not change storage.
- R9: A command whose byte address is at or above NUM_PAGES×1024 is refused. It sets the range-error bit, starts no busy period and modifies nothing.
- R10: Completion sets the sticky done bit. `irq_o` follows that bit. Writing status with bit 1 set clears it, but a completion in the same cycle wins. Bits 2 and 3 are cleared the same way.
- R11: Memory-port reads made while an operation is busy return the contents present at that moment. During a program, this is the old word until completion.
- R12: Writes to CSR index 2 with a value other than 1, 2 or 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Memory-port access request |
| bus_we_i | input | 1 | Memory-port write flag (write is dropped) |
| bus_addr_i | input | 32 | Memory-port byte address |
| bus_wdata_i | input | 32 | Memory-port write data (ignored) |
| bus_rdata_o | output | 32 | Memory-port read data, registered |
| bus_rvalid_o | output | 1 | Read data valid |
| csr_we_i | input | 1 | Register write strobe |
| csr_idx_i | input | 3 | Register index: 0 address, 1 operand, 2 command, 3 status, 4 read result |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Completion interrupt, level |

## Verification
Two things can meet in the same clock cycle: an operation finishing and software clearing the done bit with a write-one-to-clear. The bench provokes this with a read command, which lasts one cycle. It holds the write strobe across two edges so that the status clear lands on the exact edge where the read completes. It then expects done, and with it the interrupt, to remain set. A second case places a memory-port read inside a program's busy window and expects the pre-program word to come back.

// File: rtl/eflash_pkg.sv
package eflash_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_ERASE = 2'd2,
      OP_PROG  = 2'd3
   } flash_op_e;

   localparam logic [2:0] CSR_ADDR   = 3'd0;
   localparam logic [2:0] CSR_WDATA  = 3'd1;
   localparam logic [2:0] CSR_CMD    = 3'd2;
   localparam logic [2:0] CSR_STATUS = 3'd3;
   localparam logic [2:0] CSR_RDATA  = 3'd4;

   localparam int ST_BUSY   = 0;
   localparam int ST_DONE   = 1;
   localparam int ST_EBUSY  = 2;
   localparam int ST_ERANGE = 3;

   localparam logic [31:0] ERASED_WORD = 32'hFFFF_FFFF;

endpackage

// File: rtl/eflash_store.sv
module eflash_store #(
   parameter int WORDS = 1024,
   localparam int IW = $clog2(WORDS)
) (
   input  logic          clk_i,
   input  logic          bus_re_i,
   input  logic          bus_ok_i,
   input  logic [IW-1:0] bus_idx_i,
   output logic [31:0]   bus_rdata_o,
   input  logic [IW-1:0] look_idx_i,
   output logic [31:0]   look_rdata_o,
   input  logic          wr_en_i,
   input  logic [IW-1:0] wr_idx_i,
   input  logic [31:0]   wr_data_i
);

   logic [31:0] cells_q [WORDS];
   logic [31:0] bus_rdata_q;

   always_ff @(posedge clk_i) begin
      if (wr_en_i) cells_q[wr_idx_i] <= wr_data_i;
   end

   always_ff @(posedge clk_i) begin
      if (bus_re_i) bus_rdata_q <= bus_ok_i ? cells_q[bus_idx_i] : '0;
   end

   assign bus_rdata_o  = bus_rdata_q;
   assign look_rdata_o = cells_q[look_idx_i];

endmodule

// File: rtl/eflash_timer.sv
module eflash_timer #(
   parameter int CW = 10
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          busy_o,
   output logic          last_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (load_i)        cnt_q <= load_val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
   assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/eflash_seq.sv
module eflash_seq
   import eflash_pkg::*;
#(
   parameter int WORDS        = 1024,
   parameter int PAGE_WORDS   = 256,
   parameter int ERASE_CYCLES = 1000,
   parameter int PROG_CYCLES  = 40,
   localparam int IW   = $clog2(WORDS),
   localparam int PW   = $clog2(PAGE_WORDS),
   localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
   localparam int CW   = $clog2(MAXC + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  flash_op_e     op_i,
   input  logic [IW-1:0] idx_i,
   input  logic [31:0]   data_i,
   input  logic [31:0]   old_word_i,
   output logic [IW-1:0] look_idx_o,
   output logic          wr_en_o,
   output logic [IW-1:0] wr_idx_o,
   output logic [31:0]   wr_data_o,
   output logic          busy_o,
   output logic          finish_o,
   output logic          capture_o
);

   localparam logic [CW-1:0] ERASE_LD = CW'(ERASE_CYCLES);
   localparam logic [CW-1:0] PROG_LD  = CW'(PROG_CYCLES);
   localparam logic [CW-1:0] READ_LD  = CW'(1);

   flash_op_e     op_q;
   logic [IW-1:0] idx_q;
   logic [31:0]   data_q;
   logic [PW:0]   wipe_q;
   logic          last;
   logic          wiping;
   logic [CW-1:0] load_val;

   always_comb begin
      unique case (op_i)
         OP_ERASE: load_val = ERASE_LD;
         OP_PROG:  load_val = PROG_LD;
         default:  load_val = READ_LD;
      endcase
   end

   eflash_timer #(.CW(CW)) timer_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (start_i),
      .load_val_i (load_val),
      .busy_o     (busy_o),
      .last_o     (last)
   );

   assign wiping    = (op_q == OP_ERASE) && !wipe_q[PW];
   assign finish_o  = (op_q != OP_NONE) && last;
   assign capture_o = (op_q == OP_READ) && last;
   assign look_idx_o = idx_q;

   always_comb begin
      wr_en_o   = 1'b0;
      wr_idx_o  = idx_q;
      wr_data_o = old_word_i & data_q;
      if (wiping) begin
         wr_en_o   = 1'b1;
         wr_idx_o  = {idx_q[IW-1:PW], wipe_q[PW-1:0]};
         wr_data_o = ERASED_WORD;
      end else if ((op_q == OP_PROG) && last) begin
         wr_en_o = 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         op_q   <= OP_NONE;
         idx_q  <= '0;
         data_q <= '0;
         wipe_q <= '0;
      end else if (start_i) begin
         op_q   <= op_i;
         idx_q  <= idx_i;
         data_q <= data_i;
         wipe_q <= '0;
      end else begin
         if (finish_o) op_q <= OP_NONE;
         if (wiping)   wipe_q <= wipe_q + 1'b1;
      end
   end

endmodule

// File: rtl/eflash_ctrl_top.sv
module eflash_ctrl_top
   import eflash_pkg::*;
#(
   parameter int NUM_PAGES    = 4,
   parameter int PAGE_WORDS   = 256,
   parameter int ERASE_CYCLES = 1000,
   parameter int PROG_CYCLES  = 40,
   localparam int WORDS = NUM_PAGES * PAGE_WORDS,
   localparam int IW    = $clog2(WORDS)
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        bus_req_i,
   input  logic        bus_we_i,
   input  logic [31:0] bus_addr_i,
   input  logic [31:0] bus_wdata_i,
   output logic [31:0] bus_rdata_o,
   output logic        bus_rvalid_o,
   input  logic        csr_we_i,
   input  logic [2:0]  csr_idx_i,
   input  logic [31:0] csr_wdata_i,
   output logic [31:0] csr_rdata_o,
   output logic        irq_o
);

   localparam logic [31:0] BYTE_LIMIT = 32'(WORDS * 4);

   if (NUM_PAGES < 2) begin : g_chk_pages
      $error("NUM_PAGES must be at least 2");
   end
   if ((PAGE_WORDS < 2) || ((PAGE_WORDS & (PAGE_WORDS - 1)) != 0)) begin : g_chk_page
      $error("PAGE_WORDS must be a power of two");
   end
   if (ERASE_CYCLES < PAGE_WORDS) begin : g_chk_erase
      $error("ERASE_CYCLES must cover one write per page word");
   end
   if (PROG_CYCLES < 1) begin : g_chk_prog
      $error("PROG_CYCLES must be at least 1");
   end

   logic [31:0] addr_q, wdata_q, rdata_q;
   logic        done_q, err_busy_q, err_range_q, rvalid_q;
   logic        busy, finish, capture;
   logic        cmd_wr, cmd_known, cmd_range_bad, start;
   logic        clr_wr;
   logic [IW-1:0] look_idx, wr_idx;
   logic [31:0]   look_rdata, wr_data;
   logic          wr_en;
   logic          bus_re;
   logic          unused_wdata;

   assign unused_wdata = ^bus_wdata_i;

   assign cmd_wr        = csr_we_i && (csr_idx_i == CSR_CMD);
   assign cmd_known     = (csr_wdata_i[1:0] != 2'd0) && (csr_wdata_i[31:2] == '0);
   assign cmd_range_bad = (addr_q >= BYTE_LIMIT);
   assign start         = cmd_wr && cmd_known && !busy && !cmd_range_bad;
   assign clr_wr        = csr_we_i && (csr_idx_i == CSR_STATUS);
   assign bus_re        = bus_req_i && !bus_we_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_q      <= '0;
         wdata_q     <= '0;
         rdata_q     <= '0;
         done_q      <= 1'b0;
         err_busy_q  <= 1'b0;
         err_range_q <= 1'b0;
         rvalid_q    <= 1'b0;
      end else begin
         rvalid_q <= bus_re;
         if (csr_we_i && (csr_idx_i == CSR_ADDR))  addr_q  <= csr_wdata_i;
         if (csr_we_i && (csr_idx_i == CSR_WDATA)) wdata_q <= csr_wdata_i;
         if (capture) rdata_q <= look_rdata;

         if (finish)                                done_q <= 1'b1;
         else if (clr_wr && csr_wdata_i[ST_DONE])   done_q <= 1'b0;

         if (cmd_wr && cmd_known && busy)             err_busy_q <= 1'b1;
         else if (clr_wr && csr_wdata_i[ST_EBUSY])    err_busy_q <= 1'b0;

         if (cmd_wr && cmd_known && !busy && cmd_range_bad) err_range_q <= 1'b1;
         else if (clr_wr && csr_wdata_i[ST_ERANGE])         err_range_q <= 1'b0;
      end
   end

   eflash_seq #(
      .WORDS        (WORDS),
      .PAGE_WORDS   (PAGE_WORDS),
      .ERASE_CYCLES (ERASE_CYCLES),
      .PROG_CYCLES  (PROG_CYCLES)
   ) seq_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start),
      .op_i       (flash_op_e'(csr_wdata_i[1:0])),
      .idx_i      (addr_q[IW+1:2]),
      .data_i     (wdata_q),
      .old_word_i (look_rdata),
      .look_idx_o (look_idx),
      .wr_en_o    (wr_en),
      .wr_idx_o   (wr_idx),
      .wr_data_o  (wr_data),
      .busy_o     (busy),
      .finish_o   (finish),
      .capture_o  (capture)
   );

   eflash_store #(.WORDS(WORDS)) store_i (
      .clk_i        (clk_i),
      .bus_re_i     (bus_re),
      .bus_ok_i     (bus_addr_i < BYTE_LIMIT),
      .bus_idx_i    (bus_addr_i[IW+1:2]),
      .bus_rdata_o  (bus_rdata_o),
      .look_idx_i   (look_idx),
      .look_rdata_o (look_rdata),
      .wr_en_i      (wr_en),
      .wr_idx_i     (wr_idx),
      .wr_data_i    (wr_data)
   );

   always_comb begin
      unique case (csr_idx_i)
         CSR_ADDR:   csr_rdata_o = addr_q;
         CSR_WDATA:  csr_rdata_o = wdata_q;
         CSR_STATUS: csr_rdata_o = {28'd0, err_range_q, err_busy_q, done_q, busy};
         CSR_RDATA:  csr_rdata_o = rdata_q;
         default:    csr_rdata_o = '0;
      endcase
   end

   assign bus_rvalid_o = rvalid_q;
   assign irq_o        = done_q;

endmodule

// File: rtl/eflash_ctrl_chk.sv
module eflash_ctrl_chk
   import eflash_pkg::*;
(
   input logic        clk_i,
   input logic        rst_ni,
   input logic        bus_req_i,
   input logic        bus_we_i,
   input logic        bus_rvalid_o,
   input logic        csr_we_i,
   input logic [2:0]  csr_idx_i,
   input logic [31:0] csr_wdata_i,
   input logic        irq_o,
   input logic        busy,
   input logic        err_busy_q,
   input logic        err_range_q,
   input logic        cmd_range_bad
);

   logic cmd_seen;
   assign cmd_seen = csr_we_i && (csr_idx_i == CSR_CMD)
                     && (csr_wdata_i[1:0] != 2'd0) && (csr_wdata_i[31:2] == '0);

   // R2
   a_r2_read_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && !bus_we_i) |=> bus_rvalid_o);

   // R3
   a_r3_write_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && bus_we_i) |=> !bus_rvalid_o);

   // R8
   a_r8_busy_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_seen && busy) |=> err_busy_q);

   // R9
   a_r9_range_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_seen && !busy && cmd_range_bad) |=> (!busy && err_range_q));

   // R10
   a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !(csr_we_i && (csr_idx_i == CSR_STATUS) && csr_wdata_i[ST_DONE])) |=> irq_o);

   // R6
   a_r6_done_on_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy) |-> irq_o);

endmodule

bind eflash_ctrl_top eflash_ctrl_chk chk_i (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .bus_req_i     (bus_req_i),
   .bus_we_i      (bus_we_i),
   .bus_rvalid_o  (bus_rvalid_o),
   .csr_we_i      (csr_we_i),
   .csr_idx_i     (csr_idx_i),
   .csr_wdata_i   (csr_wdata_i),
   .irq_o         (irq_o),
   .busy          (busy),
   .err_busy_q    (err_busy_q),
   .err_range_q   (err_range_q),
   .cmd_range_bad (cmd_range_bad)
);

// File: tb/eflash_ctrl_top_tb_top.sv
module eflash_ctrl_top_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NP = 4, PWD = 256, EC = 1000, PC = 40, NW = NP * PWD;
   localparam logic [2:0] I_ADDR = 3'd0, I_WDATA = 3'd1, I_CMD = 3'd2, I_STAT = 3'd3, I_RDAT = 3'd4;
   localparam logic [31:0] C_READ = 32'd1, C_ERASE = 32'd2, C_PROG = 32'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
   logic        bus_rvalid;
   logic        csr_we = 1'b0;
   logic [2:0]  csr_idx = '0;
   logic [31:0] csr_wdata = '0, csr_rdata;
   logic        irq;

   logic [31:0] model [NW];
   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   eflash_ctrl_top #(.NUM_PAGES(NP), .PAGE_WORDS(PWD), .ERASE_CYCLES(EC), .PROG_CYCLES(PC)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
      .csr_we_i(csr_we), .csr_idx_i(csr_idx), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
      .irq_o(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic csr_write(input logic [2:0] idx, input logic [31:0] v);
      @(negedge clk); csr_we = 1'b1; csr_idx = idx; csr_wdata = v;
      @(negedge clk); csr_we = 1'b0;
   endtask

   task automatic csr_read(input logic [2:0] idx, output logic [31:0] v);
      @(negedge clk); csr_idx = idx; #0.5; v = csr_rdata;
   endtask

   task automatic mem_read(input logic [31:0] a, output logic [31:0] d, output logic v);
      @(negedge clk); bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk); bus_req = 1'b0; d = bus_rdata; v = bus_rvalid;
   endtask

   task automatic mem_write(input logic [31:0] a, input logic [31:0] d, output logic v);
      @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_req = 1'b0; bus_we = 1'b0; v = bus_rvalid;
   endtask

   task automatic start_cmd(input logic [31:0] op, input logic [31:0] a, input logic [31:0] d);
      csr_write(I_ADDR, a);
      csr_write(I_WDATA, d);
      csr_write(I_CMD, op);
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      csr_idx = I_STAT; #0.5;
      while (csr_rdata[0] && cyc < 5000) begin
         @(negedge clk); csr_idx = I_STAT; #0.5; cyc++;
      end
   endtask

   function automatic int word_of(input logic [31:0] a);
      return int'(a[31:2]);
   endfunction

   task automatic model_erase(input int page);
      for (int w = 0; w < PWD; w++) model[page * PWD + w] = 32'hFFFF_FFFF;
   endtask

   task automatic verify_all(input string tag);
      int bad = 0;
      logic [31:0] d; logic v;
      for (int w = 0; w < NW; w++) begin
         mem_read(32'(w * 4), d, v);
         if (d !== model[w] || v !== 1'b1) bad++;
      end
      check(tag, 32'(bad), 32'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R6 actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, d;
      logic vld;
      int cyc;
      void'($urandom(32'd7321));

      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      csr_read(I_STAT, v);
      check("R1 status after reset", v, 32'd0);
      check("R1 irq after reset", {31'd0, irq}, 32'd0);

      for (int p = 0; p < NP; p++) begin
         start_cmd(C_ERASE, 32'(p * 1024), 32'd0);
         wait_idle(cyc);
         model_erase(p);
         if (p == 0) begin
            check("R6 erase busy length", 32'(cyc), 32'(EC));
            check("R10 irq after erase", {31'd0, irq}, 32'd1);
            csr_read(I_STAT, v);
            check("R10 done bit set", v, 32'd2);
         end
         csr_write(I_STAT, 32'hE);
      end
      check("R10 irq cleared", {31'd0, irq}, 32'd0);
      verify_all("R4 all pages erased");

      start_cmd(C_PROG, 32'h10, 32'hFFFF_0000);
      wait_idle(cyc);
      check("R6 program busy length", 32'(cyc), 32'(PC));
      start_cmd(C_PROG, 32'h10, 32'h00FF_00FF);
      wait_idle(cyc);
      model[4] = 32'h00FF_0000;
      mem_read(32'h10, d, vld);
      check("R5 repeated program ANDs", d, 32'h00FF_0000);
      check("R2 rvalid on read", {31'd0, vld}, 32'd1);

      mem_write(32'h10, 32'hFFFF_FFFF, vld);
      check("R3 no rvalid on write", {31'd0, vld}, 32'd0);
      mem_read(32'h10, d, vld);
      check("R3 write through bus ignored", d, model[4]);
      csr_write(I_STAT, 32'hE);

      for (int i = 0; i < 24; i++) begin
         int w;
         logic [31:0] dat;
         w = int'($urandom % NP) * PWD + int'($urandom % 8);
         dat = $urandom;
         start_cmd(C_PROG, 32'(w * 4), dat);
         wait_idle(cyc);
         model[w] = model[w] & dat;
         mem_read(32'(w * 4), d, vld);
         check("R5 random program", d, model[w]);
         if (i % 4 == 0) begin
            start_cmd(C_READ, 32'(w * 4), 32'd0);
            wait_idle(cyc);
            check("R6 read busy length", 32'(cyc), 32'd1);
            csr_read(I_RDAT, v);
            check("R7 read command result", v, model[w]);
         end
         csr_write(I_STAT, 32'hE);
      end

      start_cmd(C_PROG, 32'h20, 32'h0);
      mem_read(32'h20, d, vld);
      check("R11 read during program busy", d, model[8]);
      wait_idle(cyc);
      model[8] = 32'h0;
      mem_read(32'h20, d, vld);
      check("R11 read after program", d, 32'h0);
      csr_write(I_STAT, 32'hE);

      start_cmd(C_ERASE, 32'h400, 32'd0);
      start_cmd(C_PROG, 32'h0C, 32'h0);
      csr_read(I_STAT, v);
      check("R8 busy error flagged", v & 32'h5, 32'h5);
      wait_idle(cyc);
      model_erase(1);
      mem_read(32'h0C, d, vld);
      check("R8 rejected program no effect", d, model[3]);
      csr_write(I_STAT, 32'hE);

      start_cmd(C_PROG, 32'h1000, 32'h0);
      csr_read(I_STAT, v);
      check("R9 range refused status", v, 32'h8);
      mem_read(32'h0, d, vld);
      check("R9 aliased word untouched", d, model[0]);
      start_cmd(C_ERASE, 32'hFFFF_FFFC, 32'd0);
      csr_read(I_STAT, v);
      check("R9 far address refused", v, 32'h8);
      csr_write(I_STAT, 32'hE);
      verify_all("R9 storage unchanged");

      csr_write(I_CMD, 32'd0);
      csr_read(I_STAT, v);
      check("R12 code 0 ignored", v, 32'd0);
      csr_write(I_CMD, 32'd6);
      csr_read(I_STAT, v);
      check("R12 code 6 ignored", v, 32'd0);

      csr_write(I_ADDR, 32'h10);
      @(negedge clk); csr_we = 1'b1; csr_idx = I_CMD; csr_wdata = C_READ;
      @(negedge clk); csr_idx = I_STAT; csr_wdata = 32'h2;
      @(negedge clk); csr_we = 1'b0;
      csr_read(I_STAT, v);
      check("R10 completion beats same-cycle clear", v, 32'h2);
      csr_read(I_RDAT, v);
      check("R7 read result after race", v, model[4]);
      csr_write(I_STAT, 32'h2);
      check("R10 clear drops irq", {31'd0, irq}, 32'd0);

      for (int p = 1; p < NP; p++) begin
         start_cmd(C_PROG, 32'(p * 1024), 32'h1234_5678);
         wait_idle(cyc);
         model[p * PWD] = model[p * PWD] & 32'h1234_5678;
         start_cmd(C_PROG, 32'(p * 1024 + 1020), 32'h0F0F_0F0F);
         wait_idle(cyc);
         model[p * PWD + 255] = model[p * PWD + 255] & 32'h0F0F_0F0F;
      end
      start_cmd(C_ERASE, 32'(2 * 1024 + 512), 32'd0);
      wait_idle(cyc);
      model_erase(2);
      csr_write(I_STAT, 32'hE);
      verify_all("R4 erase only its own page");

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule